// File: doc/BRIEF.md
# Serial Target Register Port for a Calendar Clock

This block is a two-wire serial bus target that answers at the fixed 7-bit address 1101000. It samples SCL and SDA on a fast system clock and gives the bus master access to seventeen byte-wide locations, 00h to 10h, through a pointer that steps forward after each byte. A write transaction loads the pointer with its first data byte and then stores the bytes that follow. A read transaction returns bytes from wherever the pointer was left.

Locations 00h to 06h hold the running time, which lives outside the block. The target does not read those live values directly. It reads a 7-byte snapshot that it recaptures at transaction boundaries and when the pointer wraps, so a multibyte read sees one consistent instant. Every accepted data byte leaves the block as a one-cycle write strobe, so the timekeeper can load the time fields. Locations 07h to 10h are held inside the block. Location 10h also drives one decoded enable bit.

Top module: `rtc_i2c_regif`

## Requirements
- R1: After reset, sda_oe_o, wr_en_o and tc_en_o are all low. A STOP (SDA rising while SCL is high) releases SDA.
- R2: The first byte after START is acknowledged only when its upper seven bits equal 1101000. Bit 0 of that byte selects the direction: 0 is write, 1 is read. After a byte with any other address, the block does not acknowledge and gives no write strobe until the next START.
- R3: In a write, the first data byte loads the pointer. A value above 10h loads 00h. Each later byte produces a write strobe with the pointer as address and then advances the pointer.
- R4: The pointer steps from 10h back to 00h.
- R5: A read starts at the stored pointer. Bytes go out MSB first, and the pointer advances after every byte sent.
- R6: A read of address n, for n from 0 to 6, returns live_time_i[8n+7:8n] as captured at the latest START, STOP or wrap. Later changes of live_time_i are not seen until the next capture.
- R7: The target pulls SDA low during the ninth clock after a matching address byte and after each written byte. It changes SDA only while SCL is low.
- R8: A write strobe is a single-cycle pulse. It is issued at the rising SCL edge of the acknowledge clock.
- R9: Addresses 07h to 10h read back exactly as written, and reset to 00h. tc_en_o is high exactly when bits 7:4 of location 10h hold 1010.
- R10: A repeated START in the middle of a transaction returns the block to the address phase. The byte that follows it is decoded as an address.
- R11: A not-acknowledge from the master after a read byte ends the read. SDA stays released until the next START.
- R12: When the pointer wraps to 00h during a transaction, the snapshot is recaptured before the next byte is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| live_time_i | input | 56 | Live time bytes; byte n is located at bits 8n+7:8n |
| wr_en_o | output | 1 | Write strobe for one cycle |
| wr_addr_o | output | 5 | Address of the written location |
| wr_data_o | output | 8 | Written byte |
| tc_en_o | output | 1 | Decoded enable from location 10h |

## Verification
A wrong pointer shows up on the ports within one byte time. Either the wr_addr_o of the next strobe is wrong, or the next byte read back is wrong. A snapshot that is stale or captured at the wrong moment shows up as a time byte that does not match live_time_i as it was at the START or at the wrap. A fault in the bus sequencing shows up at the next acknowledge slot: SDA is driven where it should be released, or the reverse. The decoded enable is compared on every clock against the last value written to location 10h, so a decode fault appears one cycle after the strobe.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL is steadily high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/rtc_reg_store.sv
module rtc_reg_store #(
  parameter int unsigned REG_CNT  = 17,
  parameter int unsigned SNAP_CNT = 7,
  localparam int unsigned ADDR_W    = $clog2(REG_CNT),
  localparam int unsigned STORE_CNT = REG_CNT - SNAP_CNT
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SNAP_CNT*8-1:0] live_i,
  input  logic                  refresh_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic                  tc_en_o
);
  logic [7:0] snap_q [SNAP_CNT];
  logic [7:0] cfg_q  [STORE_CNT];

  for (genvar i = 0; i < SNAP_CNT; i++) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        snap_q[i] <= '0;
      else if (refresh_i) snap_q[i] <= live_i[i*8 +: 8];
    end
  end

  for (genvar i = 0; i < STORE_CNT; i++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(SNAP_CNT + i)) cfg_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < SNAP_CNT; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = snap_q[i];
    for (int i = 0; i < STORE_CNT; i++)
      if (rd_addr_i == ADDR_W'(SNAP_CNT + i)) rd_data_o = cfg_q[i];
  end

  // only the exact key pattern in the top nibble enables
  assign tc_en_o = (cfg_q[STORE_CNT-1][7:4] == 4'b1010);
endmodule

// File: rtl/rtc_i2c_regif.sv
module rtc_i2c_regif
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b1101000,
  parameter int unsigned REG_CNT     = 17,
  parameter int unsigned SNAP_CNT    = 7,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W = $clog2(REG_CNT),
  localparam int unsigned LAST   = REG_CNT - 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [SNAP_CNT*8-1:0] live_time_i,
  output logic                  wr_en_o,
  output logic [ADDR_W-1:0]     wr_addr_o,
  output logic [7:0]            wr_data_o,
  output logic                  tc_en_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  tgt_st_e           st_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        rx_q, tx_q;
  logic [ADDR_W-1:0] ptr_q, ptr_nxt;
  logic              ptr_load_q, rw_q, oe_q;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;
  logic [7:0]        rd_data;
  logic              ptr_step, wrap, refresh;

  assign ptr_nxt  = (ptr_q == ADDR_W'(LAST)) ? '0 : ptr_q + 1'b1;
  assign ptr_step = scl_rise && ((st_q == ST_WR_ACK && !ptr_load_q) || st_q == ST_RD_ACK)
                    && !start_det && !stop_det;
  assign wrap     = ptr_step && (ptr_q == ADDR_W'(LAST));
  assign refresh  = start_det || stop_det || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      ptr_load_q <= 1'b0;
      rw_q       <= 1'b0;
      oe_q       <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_det) begin
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_det) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              rx_q      <= {rx_q[6:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              if (st_q == ST_WR) begin
                oe_q <= 1'b1;
                st_q <= ST_WR_ACK;
              end else if (rx_q[7:1] == DEV_ADDR) begin
                oe_q <= 1'b1;
                rw_q <= rx_q[0];
                st_q <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              tx_q <= rd_data;
              oe_q <= ~rd_data[7];
              st_q <= ST_RD;
            end else begin
              oe_q       <= 1'b0;
              ptr_load_q <= 1'b1;
              st_q       <= ST_WR;
            end
          end
          ST_WR_ACK: begin
            if (scl_rise) begin
              if (ptr_load_q) begin
                ptr_q      <= (rx_q <= 8'(LAST)) ? rx_q[ADDR_W-1:0] : '0;
                ptr_load_q <= 1'b0;
              end else begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= rx_q;
                ptr_q     <= ptr_nxt;
              end
            end else if (scl_fall) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              st_q      <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt_q == 4'd8) begin
                oe_q <= 1'b0;
                st_q <= ST_RD_ACK;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0};
                oe_q <= ~tx_q[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              ptr_q <= ptr_nxt;
              if (sda_s) st_q <= ST_IDLE;  // master declined more data
            end else if (scl_fall) begin
              bit_cnt_q <= '0;
              tx_q      <= rd_data;
              oe_q      <= ~rd_data[7];
              st_q      <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  rtc_reg_store #(.REG_CNT(REG_CNT), .SNAP_CNT(SNAP_CNT)) u_store (
    .clk_i, .rst_ni,
    .live_i(live_time_i), .refresh_i(refresh),
    .wr_en_i(wr_en_q), .wr_addr_i(wr_addr_q), .wr_data_i(wr_data_q),
    .rd_addr_i(ptr_q), .rd_data_o(rd_data), .tc_en_o(tc_en_o)
  );

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/rtc_i2c_regif_chk.sv
module rtc_i2c_regif_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LAST   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_i,
  input logic              scl_s_i,
  input logic              stop_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic              tc_en_i
);
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i); // R1

  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i)) |-> $stable(sda_oe_i)); // R7

  AST_WR_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_addr_i <= ADDR_W'(LAST))); // R4

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i); // R8

  AST_TC_RISE_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_en_i) |-> $past(wr_en_i && wr_addr_i == ADDR_W'(LAST) && wr_data_i[7:4] == 4'b1010)); // R9

  AST_TC_FALL_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tc_en_i) |-> $past(wr_en_i && wr_addr_i == ADDR_W'(LAST))); // R9
endmodule

bind rtc_i2c_regif rtc_i2c_regif_chk #(.ADDR_W(ADDR_W), .LAST(LAST)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_i(sda_oe_o), .scl_s_i(scl_s),
  .stop_i(stop_det), .wr_en_i(wr_en_o), .wr_addr_i(wr_addr_o),
  .wr_data_i(wr_data_o), .tc_en_i(tc_en_o)
);

// File: tb/rtc_i2c_regif_test.sv
module rtc_i2c_regif_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic [55:0] live_time = 56'h06_05_04_03_02_01_00;
  logic sda_oe, wr_en, tc_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  wire sda_bus = sda_m & ~sda_oe;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit exp_tc = 0;
  logic [12:0] wr_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_i2c_regif uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .live_time_i(live_time), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .tc_en_o(tc_en)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle model: strobes logged, decoded enable follows last write of 10h
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tc_en === exp_tc, "R9 tc_en per cycle", tc_en, exp_tc);
      if (wr_en === 1'b1) begin
        wr_q.push_back({wr_addr, wr_data});
        if (wr_addr == 5'h10) exp_tc = (wr_data[7:4] == 4'b1010);
      end
    end
  end

  task automatic waitq(); repeat (Q) @(posedge clk); #1; endtask
  task automatic bstart(); sda_m = 1; waitq(); scl_m = 1; waitq(); sda_m = 0; waitq(); scl_m = 0; waitq(); endtask
  task automatic bstop(); sda_m = 0; waitq(); scl_m = 1; waitq(); sda_m = 1; waitq(); endtask
  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; waitq(); scl_m = 1; waitq(); r = sda_bus; waitq(); scl_m = 0; waitq();
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = (r == 1'b0);
  endtask
  task automatic recv_byte(input bit last, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); b[i] = r; end
    clk_bit(last, r);
  endtask
  task automatic send_chk(input logic [7:0] b, input string req);
    bit ack;
    send_byte(b, ack);
    check(ack, req, ack, 1);
  endtask
  task automatic expect_wr(input string req, input logic [4:0] a, input logic [7:0] d);
    logic [12:0] e;
    if (wr_q.size() == 0) check(0, req, 13'h1fff, {a, d});
    else begin e = wr_q.pop_front(); check(e == {a, d}, req, e, {a, d}); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    logic [55:0] l1, l3;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(sda_oe == 0, "R1 reset sda_oe", sda_oe, 0);
    check(wr_en == 0, "R1 reset wr_en", wr_en, 0);
    check(tc_en == 0, "R1 reset tc_en", tc_en, 0);

    // R2: foreign address ignored
    bstart(); send_byte(8'hA0, ack);
    check(!ack, "R2 foreign address not acked", ack, 0);
    send_byte(8'h05, ack); send_byte(8'h99, ack);
    check(!ack, "R2 data after foreign address not acked", ack, 0);
    bstop();
    check(wr_q.size() == 0, "R2 no strobe", wr_q.size(), 0);
    check(sda_oe == 0, "R1 released after stop", sda_oe, 0);

    // R3/R7/R8: pointer then three data bytes
    bstart(); send_chk(8'hD0, "R7 address ack");
    send_chk(8'h08, "R7 pointer ack");
    send_chk(8'h11, "R7 data ack"); send_chk(8'h22, "R7 data ack"); send_chk(8'h33, "R7 data ack");
    bstop();
    expect_wr("R3 strobe 08h", 5'h08, 8'h11);
    expect_wr("R3 strobe 09h", 5'h09, 8'h22);
    expect_wr("R8 strobe 0Ah", 5'h0A, 8'h33);

    // R5/R11: pointer only, then read from stored pointer
    bstart(); send_chk(8'hD0, "R7 address ack"); send_chk(8'h09, "R3 pointer ack"); bstop();
    bstart(); send_chk(8'hD1, "R2 read address ack");
    recv_byte(0, b); check(b == 8'h22, "R5 read 09h", b, 8'h22);
    recv_byte(1, b); check(b == 8'h33, "R5 read 0Ah", b, 8'h33);
    repeat (8) @(posedge clk); #1;
    check(sda_oe == 0, "R11 released after nack", sda_oe, 0);
    bstop();

    // R4: write wrap, 10h key pattern
    bstart(); send_chk(8'hD0, "R7 address ack"); send_chk(8'h0F, "R3 pointer ack");
    send_chk(8'h5A, "R7 data ack"); send_chk(8'hA5, "R7 data ack"); send_chk(8'h77, "R7 data ack");
    bstop();
    expect_wr("R4 strobe 0Fh", 5'h0F, 8'h5A);
    expect_wr("R4 strobe 10h", 5'h10, 8'hA5);
    expect_wr("R4 wrap to 00h", 5'h00, 8'h77);
    check(tc_en == 1, "R9 key pattern enables", tc_en, 1);

    // R9/R10: other pattern, read back via repeated start
    bstart(); send_chk(8'hD0, "R7 address ack"); send_chk(8'h10, "R3 pointer ack");
    send_chk(8'hB5, "R7 data ack"); bstop();
    expect_wr("R9 strobe 10h", 5'h10, 8'hB5);
    check(tc_en == 0, "R9 other pattern disables", tc_en, 0);
    bstart(); send_chk(8'hD0, "R7 address ack"); send_chk(8'h10, "R3 pointer ack");
    bstart(); send_chk(8'hD1, "R10 address after repeated start");
    recv_byte(1, b); check(b == 8'hB5, "R9 readback 10h", b, 8'hB5);
    bstop();

    // R10: repeated start in a write
    bstart(); send_chk(8'hD0, "R7 address ack"); send_chk(8'h07, "R3 pointer ack");
    send_chk(8'h44, "R7 data ack");
    bstart(); send_chk(8'hD0, "R10 address ack"); send_chk(8'h0C, "R10 pointer ack");
    send_chk(8'h66, "R7 data ack"); bstop();
    expect_wr("R10 strobe 07h", 5'h07, 8'h44);
    expect_wr("R10 strobe 0Ch", 5'h0C, 8'h66);

    // R3: pointer above 10h loads 00h
    bstart(); send_chk(8'hD0, "R7 address ack"); send_chk(8'h1F, "R3 pointer ack");
    send_chk(8'hC3, "R7 data ack"); bstop();
    expect_wr("R3 out-of-range pointer", 5'h00, 8'hC3);

    // R6: snapshot held through a multibyte read
    l1 = 56'h59_12_31_07_23_59_58;
    live_time = l1;
    bstart(); send_chk(8'hD0, "R7 address ack"); send_chk(8'h00, "R3 pointer ack"); bstop();
    bstart(); send_chk(8'hD1, "R2 read address ack");
    recv_byte(0, b); check(b == l1[7:0], "R6 time byte 0", b, l1[7:0]);
    live_time = 56'hFF_FF_FF_FF_FF_FF_FF;
    for (int i = 1; i < 7; i++) begin
      recv_byte(i == 6, b);
      check(b == l1[i*8 +: 8], "R6 coherent time byte", b, l1[i*8 +: 8]);
    end
    bstop();

    // R12: wrap during read recaptures
    live_time = 56'h11_11_11_11_11_11_11;
    bstart(); send_chk(8'hD0, "R7 address ack"); send_chk(8'h0F, "R3 pointer ack"); bstop();
    bstart(); send_chk(8'hD1, "R2 read address ack");
    recv_byte(0, b); check(b == 8'h5A, "R5 read 0Fh", b, 8'h5A);
    l3 = 56'h66_55_44_33_22_21_3C;
    live_time = l3;
    recv_byte(0, b); check(b == 8'hB5, "R4 read 10h", b, 8'hB5);
    recv_byte(1, b); check(b == l3[7:0], "R12 wrap recapture", b, l3[7:0]);
    bstop();

    check(wr_q.size() == 0, "R8 no stray strobe", wr_q.size(), 0);
    repeat (4) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule